// File: doc/BRIEF.md
# Programmable-Priority Bus Arbiter with Parking

This block shares one local bus among sixteen requesting masters. The order in which masters win is not wired in. It comes from a table of sixteen 4-bit slots that software writes. Each slot names a master index, and slot 0 carries the most weight. When several masters request in the same cycle, the arbiter walks the slots from 0 upward. It grants the first master it finds whose request is active. The grant is registered and one-hot. Once a master holds the bus it keeps it until it drops its request, so no master is ever preempted.

When nobody requests, the bus can be parked on one of four masters, chosen by a field in the control register. Any other code in that field turns parking off. A separate data-bus grant follows the transfer-start strobe. It comes either in the same cycle as the strobe or one cycle later, depending on a delay bit, and in both cases only while the data bus is not busy.

Software reaches the control register and the two table words through a small write/read port. A write takes effect at the next clock edge. A read is combinational.

Top module: `prio_bus_arbiter`

## Requirements
- R1: After reset the following values hold:
  - the control register reads 0x00000002, which is parking code 2 with the delay bit cleared;
  - table word 1 reads 0x01234567;
  - table word 2 reads 0x89ABCDEF;
  - `gnt` is all zero until the first clock edge after reset.
- R2: A write with `reg_we` high stores `reg_wdata` at the next rising edge, at the address on `reg_addr`. Address 0 is control, address 1 is table word 1 and address 2 is table word 2. In control, bits [3:0] are the parking code and bit 4 is the delay bit. All other control bits, and every bit at address 3, read as zero whatever was written.
- R3: Slot k of the table sits as follows:
  - slots 0 to 7 are in table word 1, and slots 8 to 15 are in table word 2;
  - within each word, the lowest-numbered slot is in bits [31:28] and each later slot is in the next lower nibble.

  When the bus is free and requests are present, the next grant goes to the master named in the lowest-numbered slot whose master has `req` high.
- R4: `gnt` is registered. It changes only on a rising edge, and at most one bit of it is set.
- R5: While the granted master keeps its `req` bit high, `gnt` does not change, even if a master with more weight starts requesting. Arbitration happens again in the cycle after the holder lowers its request.
- R6: If a master index appears in several slots, only its lowest-numbered slot counts. A master whose index is in no slot is never granted.
- R7: Parking codes 0 to 3 name masters 0 to 3. When `req` is all zero and the bus is not held, the next `gnt` selects the parked master. A parked master that is not requesting loses the bus to any requester one edge later.
- R8: Parking codes 4 to 15 are reserved and turn parking off. With a reserved code and no requests, `gnt` is all zero.
- R9: With the delay bit at 0, `dbg` equals `ts & ~dbusy` in the same cycle.
- R10: With the delay bit at 1, `dbg` is high exactly in a cycle that follows a cycle with `ts` high, while `dbusy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address (0 control, 1 and 2 table words, 3 unused) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| req | input | 16 | Bus request, one bit per master |
| gnt | output | 16 | Registered one-hot address grant |
| ts | input | 1 | Transfer-start strobe |
| dbusy | input | 1 | Data bus busy |
| dbg | output | 1 | Data-bus grant |

## Verification
Priority is driven with every single-master request and with about 150 pseudo-random multi-request vectors per table. Four tables are used: the reset table, a reversed table, a shuffled permutation and a table full of duplicates. Single requests show that every index is reachable and that each nibble maps to the right slot. The mixed vectors tell a correct first-match scan apart from a scan that runs the wrong way or that picks the last match. The duplicate table separates "first slot counts" from "any slot counts" and proves that absent masters starve. Parking is swept over all sixteen codes. The data grant is tried with every combination of strobe, busy and previous strobe, under both settings of the delay bit.

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int NM         = 16,
  parameter int RW         = 32,
  parameter int PARK_CODES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic [NM-1:0] req,
  output logic [NM-1:0] gnt,
  input  logic          ts,
  input  logic          dbusy,
  output logic          dbg
);
  localparam int SW    = $clog2(NM);
  localparam int TBITS = NM * SW;

  function automatic logic [TBITS-1:0] tbl_init();
    logic [TBITS-1:0] t;
    for (int i = 0; i < NM; i++) t[TBITS-1-i*SW -: SW] = SW'(i);
    return t;
  endfunction

  localparam logic [TBITS-1:0] TBL_RST = tbl_init();

  logic [SW-1:0]    park_q;
  logic             dgd_q;
  logic [RW-1:0]    tab1_q, tab2_q;
  logic             ts_q;
  logic [NM-1:0]    pick, park_vec;
  logic [TBITS-1:0] tbl;
  logic             hold;

  assign tbl      = {tab1_q, tab2_q};
  assign hold     = |(gnt & req);
  assign park_vec = (int'(park_q) < PARK_CODES) ? ({{(NM-1){1'b0}}, 1'b1} << park_q) : '0;
  assign dbg      = (dgd_q ? ts_q : ts) & ~dbusy;

  always_comb begin
    logic found;
    logic [SW-1:0] s;
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NM; i++) begin
      s = tbl[TBITS-1-i*SW -: SW];
      if (!found && req[s]) begin
        pick[s] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = RW'({dgd_q, park_q});
      2'd1:    reg_rdata = tab1_q;
      2'd2:    reg_rdata = tab2_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      park_q <= SW'(2);
      dgd_q  <= 1'b0;
      tab1_q <= TBL_RST[TBITS-1 -: RW];
      tab2_q <= TBL_RST[RW-1:0];
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: begin
          park_q <= reg_wdata[SW-1:0];
          dgd_q  <= reg_wdata[SW];
        end
        2'd1:    tab1_q <= reg_wdata;
        2'd2:    tab2_q <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      gnt  <= '0;
      ts_q <= 1'b0;
    end else begin
      ts_q <= ts;
      if (hold)      gnt <= gnt;
      else if (|req) gnt <= pick;
      else           gnt <= park_vec;
    end
  end
endmodule

module prio_bus_arbiter_chk #(
  parameter int NM = 16,
  parameter int SW = 4,
  parameter int PARK_CODES = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [NM-1:0] req,
  input logic [NM-1:0] gnt,
  input logic          ts,
  input logic          dbusy,
  input logic          dbg,
  input logic          dgd,
  input logic [SW-1:0] park
);
  a_r4_onehot_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  a_r3_grant_requester: assert property (@(posedge clk) disable iff (rst)
    (gnt != '0 && $past(req) != '0) |-> (gnt & $past(req)) != '0);

  a_r5_no_preempt: assert property (@(posedge clk) disable iff (rst)
    ((gnt & req) != '0) |=> gnt == $past(gnt));

  a_r7_park_grant: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req) == '0 && int'($past(park)) < PARK_CODES)
      |-> gnt == ({{(NM-1){1'b0}}, 1'b1} << $past(park)));

  a_r8_park_off: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req) == '0 && int'($past(park)) >= PARK_CODES)
      |-> gnt == '0);

  a_r9_same_cycle: assert property (@(posedge clk) disable iff (rst)
    !dgd |-> (dbg == (ts && !dbusy)));

  a_r10_one_late: assert property (@(posedge clk) disable iff (rst)
    (dgd && !$past(rst)) |-> (dbg == ($past(ts) && !dbusy)));
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.NM(NM), .SW(SW), .PARK_CODES(PARK_CODES)) u_chk (
  .clk(clk), .rst(rst), .req(req), .gnt(gnt), .ts(ts), .dbusy(dbusy),
  .dbg(dbg), .dgd(dgd_q), .park(park_q)
);

// File: tb/sim_prio_bus_arbiter.sv
module sim_prio_bus_arbiter;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [15:0] req, gnt;
  logic        ts, dbusy, dbg;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  prio_bus_arbiter u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req(req), .gnt(gnt),
    .ts(ts), .dbusy(dbusy), .dbg(dbg)
  );

  task automatic chk(string r, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  function automatic logic [15:0] model(logic [63:0] t, logic [15:0] r);
    for (int i = 0; i < 16; i++) begin
      logic [3:0] s;
      s = t[63-4*i -: 4];
      if (r[s]) return 16'b1 << s;
    end
    return '0;
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] e, string r);
    reg_addr = a;
    #1;
    chk(r, reg_rdata, e);
  endtask

  task automatic arb(logic [63:0] t, logic [15:0] r, string tag);
    req = r;
    @(negedge clk);
    chk(tag, 32'(gnt), 32'(model(t, r)));
    req = '0;
    @(negedge clk);
  endtask

  task automatic sweep(logic [63:0] t, string tag);
    logic [15:0] lf;
    wr(2'd1, t[63:32]);
    wr(2'd2, t[31:0]);
    for (int m = 0; m < 16; m++) arb(t, 16'b1 << m, tag);
    lf = 16'hACE1;
    for (int k = 0; k < 150; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      arb(t, lf, tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic prev_ts;
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    req = '0; ts = 1'b0; dbusy = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 gnt", 32'(gnt), 32'h0);
    rd(2'd0, 32'h0000_0002, "R1 ctrl");
    rd(2'd1, 32'h0123_4567, "R1 tab1");
    rd(2'd2, 32'h89AB_CDEF, "R1 tab2");
    rd(2'd3, 32'h0, "R2 addr3");
    @(negedge clk);
    chk("R7 parked on 2", 32'(gnt), 32'h0004);
    // R2 register access, reserved bits read zero
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, 32'h0000_001F, "R2 ctrl reserved");
    wr(2'd0, 32'h0000_000F);
    rd(2'd0, 32'h0000_000F, "R2 ctrl write");
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R2 addr3 ignored");
    @(negedge clk);
    chk("R8 no park", 32'(gnt), 32'h0);
    // R3 priority scan over several tables
    sweep(64'h0123_4567_89AB_CDEF, "R3 default table");
    sweep(64'hFEDC_BA98_7654_3210, "R3 reversed table");
    sweep(64'h3A1F_07C2_5B6D_84E9, "R3 shuffled table");
    // R6 duplicates and absent masters
    sweep(64'h5555_5555_5555_5553, "R6 duplicate table");
    arb(64'h5555_5555_5555_5553, 16'h0080, "R6 absent master");
    arb(64'h5555_5555_5555_5553, 16'hFFFF, "R6 first slot wins");
    wr(2'd1, 32'h0123_4567);
    wr(2'd2, 32'h89AB_CDEF);
    // R5 hold without preemption
    req = 16'h0200;
    @(negedge clk);
    chk("R5 first grant", 32'(gnt), 32'h0200);
    req = 16'h0201;
    @(negedge clk);
    chk("R5 no preempt", 32'(gnt), 32'h0200);
    @(negedge clk);
    chk("R5 still held", 32'(gnt), 32'h0200);
    req = 16'h0001;
    @(negedge clk);
    chk("R5 rearbitrate", 32'(gnt), 32'h0001);
    req = '0;
    @(negedge clk);
    // R7 and R8 parking codes
    for (int c = 0; c < 16; c++) begin
      wr(2'd0, 32'(c));
      @(negedge clk);
      if (c < 4) chk("R7 park code", 32'(gnt), 32'(16'b1 << c));
      else       chk("R8 reserved code", 32'(gnt), 32'h0);
    end
    wr(2'd0, 32'h2);
    @(negedge clk);
    req = 16'h0001;
    @(negedge clk);
    chk("R7 parked yields", 32'(gnt), 32'h0001);
    req = '0;
    // R9 no delay
    wr(2'd0, 32'h0F);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ts = i[0]; dbusy = i[1];
      #1;
      chk("R9 dbg", 32'(dbg), 32'(i[0] & ~i[1]));
    end
    @(negedge clk);
    ts = 1'b0; dbusy = 1'b0;
    // R10 one-cycle delay
    wr(2'd0, 32'h1F);
    prev_ts = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      ts = i[0] ^ i[2]; dbusy = i[1];
      #1;
      chk("R10 dbg", 32'(dbg), 32'(prev_ts & ~i[1]));
      prev_ts = ts;
    end
    ts = 1'b0; dbusy = 1'b0;
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule